// File: doc/BRIEF.md
# DMA Element Address Generator

This block works out the next source and destination byte addresses for one DMA channel each time an element moves. The channel's controller gives it the current pair of addresses, an element-width code, a stepping mode for each side and a bit that chooses one of two shared offset registers. On the clock edge where the advance strobe is high, the block registers the new addresses. The controller then uses them for the next element and feeds them back as the current addresses.

Each side steps on its own. It can hold its address, move up or down by the element's byte width, or add a signed offset taken from the chosen shared register. The same offset register serves both sides. The block only produces addresses. It does not issue bus transactions, count frames or arbitrate.

Top module: `dma_addr_gen`

## Requirements
- R1: While rst_ni is low, src_addr_o and dst_addr_o are zero.
- R2: The width code size_i sets the step in bytes: 00 gives 4, 01 gives 2 and 10 gives 1.
- R3: Mode 00 on a side's direction input leaves that side's address unchanged: the output takes the current input address.
- R4: Mode 01 adds the step to the current address.
- R5: Mode 10 subtracts the step from the current address.
- R6: Mode 11 adds the offset register picked by idx_sel_i: 0 picks idx_a_i and 1 picks idx_b_i.
- R7: Source and destination follow their own direction inputs and update on the same edge.
- R8: All address arithmetic wraps modulo 2^ADDR_W.
- R9: When adv_i is low at a clock edge, both address outputs keep their values.
- R10: The width code 11 is reserved. While it is present, size_err_o is high and no address update takes place, even with adv_i high. A valid code clears size_err_o and lets updates resume.
- R11: An offset register of IDX_W bits is a two's-complement value and is sign-extended to ADDR_W bits before the add.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| adv_i | input | 1 | Element advance strobe |
| size_i | input | 2 | Element width code |
| src_dir_i | input | 2 | Source step mode |
| dst_dir_i | input | 2 | Destination step mode |
| idx_sel_i | input | 1 | Offset register select |
| idx_a_i | input | IDX_W | Shared offset register A |
| idx_b_i | input | IDX_W | Shared offset register B |
| src_addr_i | input | ADDR_W | Current source address |
| dst_addr_i | input | ADDR_W | Current destination address |
| src_addr_o | output | ADDR_W | Updated source address |
| dst_addr_o | output | ADDR_W | Updated destination address |
| size_err_o | output | 1 | Reserved width code present |

## Verification
The bench builds the block with ADDR_W at 32 and IDX_W at 16. With offsets narrower than addresses, the sign-extension path (R11) is reachable through a negative offset in register B. With 32-bit addresses, the wrap cases at both ends of the space (R8) can be driven with literal values near 0 and 2^32. Directed scenarios cover every width code and mode on each side, and mixed modes across the two sides.

// File: rtl/dma_addr_pkg.sv
package dma_addr_pkg;
  typedef enum logic [1:0] {
    ESZ_WORD = 2'b00,
    ESZ_HALF = 2'b01,
    ESZ_BYTE = 2'b10,
    ESZ_RSVD = 2'b11
  } elem_size_e;

  typedef enum logic [1:0] {
    STEP_HOLD  = 2'b00,
    STEP_UP    = 2'b01,
    STEP_DOWN  = 2'b10,
    STEP_INDEX = 2'b11
  } step_mode_e;

  localparam int NUM_SIDES = 2;
  localparam int SIDE_SRC  = 0;
  localparam int SIDE_DST  = 1;
endpackage

// File: rtl/elem_width_dec.sv
module elem_width_dec
  import dma_addr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [1:0]        size_code_i,
  output logic [ADDR_W-1:0] bytes_o,
  output logic              rsvd_o
);
  logic [2:0] nbytes;

  always_comb begin
    nbytes = 3'd0;
    rsvd_o = 1'b0;
    unique case (elem_size_e'(size_code_i))
      ESZ_WORD: nbytes = 3'd4;
      ESZ_HALF: nbytes = 3'd2;
      ESZ_BYTE: nbytes = 3'd1;
      ESZ_RSVD: rsvd_o = 1'b1;
      default:  rsvd_o = 1'b1;
    endcase
  end

  assign bytes_o = ADDR_W'(nbytes);
endmodule

// File: rtl/index_sel.sv
module index_sel #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 32
) (
  input  logic [IDX_W-1:0]  idx_a_i,
  input  logic [IDX_W-1:0]  idx_b_i,
  input  logic              sel_i,
  output logic [ADDR_W-1:0] offs_o
);
  logic [IDX_W-1:0] picked;

  assign picked = sel_i ? idx_b_i : idx_a_i;

  generate
    if (IDX_W >= ADDR_W) begin : g_trunc
      assign offs_o = picked[ADDR_W-1:0];
    end else begin : g_sext
      assign offs_o = {{(ADDR_W-IDX_W){picked[IDX_W-1]}}, picked};
    end
  endgenerate
endmodule

// File: rtl/addr_step.sv
module addr_step
  import dma_addr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [1:0]        mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] bytes_i,
  input  logic [ADDR_W-1:0] offs_i,
  output logic [ADDR_W-1:0] next_o
);
  // modulo 2^ADDR_W arithmetic by truncation
  always_comb begin
    unique case (step_mode_e'(mode_i))
      STEP_HOLD:  next_o = addr_i;
      STEP_UP:    next_o = addr_i + bytes_i;
      STEP_DOWN:  next_o = addr_i - bytes_i;
      STEP_INDEX: next_o = addr_i + offs_i;
      default:    next_o = addr_i;
    endcase
  end
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
  import dma_addr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic [1:0]        size_i,
  input  logic [1:0]        src_dir_i,
  input  logic [1:0]        dst_dir_i,
  input  logic              idx_sel_i,
  input  logic [IDX_W-1:0]  idx_a_i,
  input  logic [IDX_W-1:0]  idx_b_i,
  input  logic [ADDR_W-1:0] src_addr_i,
  input  logic [ADDR_W-1:0] dst_addr_i,
  output logic [ADDR_W-1:0] src_addr_o,
  output logic [ADDR_W-1:0] dst_addr_o,
  output logic              size_err_o
);
  logic [ADDR_W-1:0] step_bytes;
  logic [ADDR_W-1:0] offs;
  logic              rsvd;
  logic              upd_en;

  logic [ADDR_W-1:0] cur_addr [NUM_SIDES];
  logic [1:0]        mode     [NUM_SIDES];
  logic [ADDR_W-1:0] nxt_addr [NUM_SIDES];
  logic [ADDR_W-1:0] addr_q   [NUM_SIDES];

  elem_width_dec #(.ADDR_W(ADDR_W)) u_width (
    .size_code_i (size_i),
    .bytes_o     (step_bytes),
    .rsvd_o      (rsvd)
  );

  index_sel #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_idx (
    .idx_a_i (idx_a_i),
    .idx_b_i (idx_b_i),
    .sel_i   (idx_sel_i),
    .offs_o  (offs)
  );

  assign cur_addr[SIDE_SRC] = src_addr_i;
  assign cur_addr[SIDE_DST] = dst_addr_i;
  assign mode[SIDE_SRC]     = src_dir_i;
  assign mode[SIDE_DST]     = dst_dir_i;

  // reserved width code blocks the update
  assign upd_en = adv_i & ~rsvd;

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    addr_step #(.ADDR_W(ADDR_W)) u_step (
      .mode_i  (mode[s]),
      .addr_i  (cur_addr[s]),
      .bytes_i (step_bytes),
      .offs_i  (offs),
      .next_o  (nxt_addr[s])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     addr_q[s] <= '0;
      else if (upd_en) addr_q[s] <= nxt_addr[s];
    end
  end

  assign src_addr_o = addr_q[SIDE_SRC];
  assign dst_addr_o = addr_q[SIDE_DST];
  assign size_err_o = rsvd;
endmodule

// File: rtl/dma_addr_gen_chk.sv
module dma_addr_gen_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              adv_i,
  input logic [1:0]        size_i,
  input logic [1:0]        src_dir_i,
  input logic [1:0]        dst_dir_i,
  input logic [ADDR_W-1:0] src_addr_i,
  input logic [ADDR_W-1:0] dst_addr_i,
  input logic [ADDR_W-1:0] src_addr_o,
  input logic [ADDR_W-1:0] dst_addr_o,
  input logic              size_err_o
);
  a_r9_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> ($stable(src_addr_o) && $stable(dst_addr_o)));

  a_r10_rsvd_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && size_i == 2'b11) |=> ($stable(src_addr_o) && $stable(dst_addr_o)));

  a_r10_err_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (size_i == 2'b11) |-> size_err_o);

  a_r3_src_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && size_i != 2'b11 && src_dir_i == 2'b00) |=> (src_addr_o == $past(src_addr_i)));

  a_r4_word_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && size_i == 2'b00 && src_dir_i == 2'b01)
      |=> (src_addr_o == $past(src_addr_i) + ADDR_W'(4)));

  a_r5_byte_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && size_i == 2'b10 && dst_dir_i == 2'b10)
      |=> (dst_addr_o == $past(dst_addr_i) - ADDR_W'(1)));
endmodule

bind dma_addr_gen dma_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .adv_i      (adv_i),
  .size_i     (size_i),
  .src_dir_i  (src_dir_i),
  .dst_dir_i  (dst_dir_i),
  .src_addr_i (src_addr_i),
  .dst_addr_i (dst_addr_i),
  .src_addr_o (src_addr_o),
  .dst_addr_o (dst_addr_o),
  .size_err_o (size_err_o)
);

// File: tb/tb_dma_addr_gen.sv
module tb_dma_addr_gen;
  localparam int ADDR_W = 32;
  localparam int IDX_W  = 16;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              adv_i = 1'b0;
  logic [1:0]        size_i = 2'b00;
  logic [1:0]        src_dir_i = 2'b00;
  logic [1:0]        dst_dir_i = 2'b00;
  logic              idx_sel_i = 1'b0;
  logic [IDX_W-1:0]  idx_a_i = '0;
  logic [IDX_W-1:0]  idx_b_i = '0;
  logic [ADDR_W-1:0] src_addr_i = '0;
  logic [ADDR_W-1:0] dst_addr_i = '0;
  logic [ADDR_W-1:0] src_addr_o;
  logic [ADDR_W-1:0] dst_addr_o;
  logic              size_err_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  dma_addr_gen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) dut (.*);

  task automatic chk(input string tag, input logic [ADDR_W-1:0] act, input logic [ADDR_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive at negedge, let one posedge pass, sample at next negedge
  task automatic step(input logic adv, input logic [1:0] sz, input logic [1:0] sd, input logic [1:0] dd,
                      input logic sel, input logic [ADDR_W-1:0] sa, input logic [ADDR_W-1:0] da);
    adv_i = adv; size_i = sz; src_dir_i = sd; dst_dir_i = dd;
    idx_sel_i = sel; src_addr_i = sa; dst_addr_i = da;
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic t_reset;
    chk("R1 src reset", src_addr_o, '0);
    chk("R1 dst reset", dst_addr_o, '0);
    chk("R1 err reset", ADDR_W'(size_err_o), '0);
  endtask

  task automatic t_up;
    step(1, 2'b00, 2'b01, 2'b01, 0, 32'h1000, 32'h4000);
    chk("R2 R4 src word up", src_addr_o, 32'h1004);
    chk("R4 dst word up", dst_addr_o, 32'h4004);
    step(1, 2'b01, 2'b01, 2'b01, 0, 32'h1000, 32'h4000);
    chk("R2 R4 half up", src_addr_o, 32'h1002);
    step(1, 2'b10, 2'b01, 2'b01, 0, 32'h1000, 32'h4000);
    chk("R2 R4 byte up", src_addr_o, 32'h1001);
  endtask

  task automatic t_down;
    step(1, 2'b00, 2'b10, 2'b10, 0, 32'h2000, 32'h2000);
    chk("R5 word down", src_addr_o, 32'h1FFC);
    step(1, 2'b01, 2'b10, 2'b10, 0, 32'h2000, 32'h2000);
    chk("R5 half down", dst_addr_o, 32'h1FFE);
    step(1, 2'b10, 2'b10, 2'b10, 0, 32'h2000, 32'h2000);
    chk("R5 byte down", dst_addr_o, 32'h1FFF);
  endtask

  task automatic t_hold;
    step(1, 2'b00, 2'b00, 2'b00, 0, 32'h3456, 32'h9ABC);
    chk("R3 src hold", src_addr_o, 32'h3456);
    chk("R3 dst hold", dst_addr_o, 32'h9ABC);
  endtask

  task automatic t_index;
    idx_a_i = 16'h0010;
    idx_b_i = 16'hFFF0;
    step(1, 2'b00, 2'b11, 2'b11, 0, 32'h5000, 32'h6000);
    chk("R6 index A", src_addr_o, 32'h5010);
    step(1, 2'b00, 2'b11, 2'b11, 1, 32'h5000, 32'h6000);
    chk("R6 R11 index B negative", src_addr_o, 32'h4FF0);
    chk("R11 dst index B", dst_addr_o, 32'h5FF0);
  endtask

  task automatic t_indep;
    step(1, 2'b00, 2'b01, 2'b10, 0, 32'h100, 32'h200);
    chk("R7 src up", src_addr_o, 32'h104);
    chk("R7 dst down", dst_addr_o, 32'h1FC);
    idx_a_i = 16'h0020;
    step(1, 2'b00, 2'b00, 2'b11, 0, 32'h100, 32'h200);
    chk("R7 src hold", src_addr_o, 32'h100);
    chk("R7 dst index", dst_addr_o, 32'h220);
  endtask

  task automatic t_wrap;
    step(1, 2'b00, 2'b01, 2'b10, 0, 32'hFFFF_FFFE, 32'h0000_0001);
    chk("R8 wrap up", src_addr_o, 32'h0000_0002);
    chk("R8 wrap down", dst_addr_o, 32'hFFFF_FFFD);
  endtask

  task automatic t_idle;
    step(0, 2'b00, 2'b01, 2'b01, 0, 32'h7777, 32'h8888);
    chk("R9 src idle", src_addr_o, 32'h0000_0002);
    chk("R9 dst idle", dst_addr_o, 32'hFFFF_FFFD);
  endtask

  task automatic t_rsvd;
    step(1, 2'b11, 2'b01, 2'b01, 0, 32'h8888, 32'h9999);
    chk("R10 err set", ADDR_W'(size_err_o), 32'h1);
    chk("R10 src blocked", src_addr_o, 32'h0000_0002);
    chk("R10 dst blocked", dst_addr_o, 32'hFFFF_FFFD);
    step(1, 2'b00, 2'b01, 2'b01, 0, 32'h8888, 32'h9999);
    chk("R10 err clear", ADDR_W'(size_err_o), 32'h0);
    chk("R10 resume", src_addr_o, 32'h888C);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_up();
    t_down();
    t_hold();
    t_index();
    t_indep();
    t_wrap();
    t_idle();
    t_rsvd();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (10000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule